// File: doc/BRIEF.md
# EPROM Program/Verify Port

This block is the device-side logic of a microcontroller program store with 12-bit words while it is being programmed in parallel. An external programmer drives a high-voltage level pin, a chip-enable pin, an increment clock pin and a 12-bit data bus. All four pins are modelled as digital levels and sampled on a system clock. Once the high-voltage level rises under the right pin conditions, the block enters program/verify mode. An internal 11-bit address counter then selects one word at a time.

The counter starts on the configuration word. Each falling edge of the increment clock steps it forward. The first step lands on user address 0x000. The counter then runs through the 512 user words into the special area, whose first four words hold a customer ID. A low pulse on chip-enable programs the bus data into the selected word. Raising the increment clock while chip-enable is high drives the word back out for verification.

A code-protect bit in the configuration word does two things. It scrambles every read down to a 4-bit nibble parity. It also blocks programming of user words from 0x040 upward.

Top module: `eprom_pgm_port`

## Requirements
- R1: After power-on reset the user words, ID words and configuration bits are erased, meaning every bit reads 1. The bus is not driven (data_oe = 0).
- R2: While hv_level is low the block is out of mode and the counter holds 0x7FF on the configuration word. Mode is entered only when hv_level rises while prog_n is high and step_clk is low. A rise under any other pin state leaves the bus undriven.
- R3: The first word read after mode entry is the configuration word. Its bits 3:0 are the stored bits: bit 3 is code protect (0 = protected), bit 2 is watchdog enable and bits 1:0 are oscillator select. Bits 11:4 read as 1.
- R4: Each falling edge of step_clk in mode advances the counter by one, and the first edge moves from 0x7FF to 0x000. Address N is therefore selected after N+1 falling edges.
- R5: Addresses 0x200–0x203 hold four writable ID words. Every other address outside 0x000–0x1FF reads 0xFFF and ignores writes.
- R6: Once the counter has left the configuration word, no number of increments selects it again. After 2048 steps, address 0x7FF reads 0xFFF. Leaving and re-entering the mode selects the configuration word again.
- R7: The bus is driven only in mode while prog_n and step_clk are both high. At all other times data_oe is 0. Bit 11 of the bus is the word's MSB.
- R8: A falling edge of prog_n in mode programs the selected word. The word becomes the bitwise AND of its old value and data_in, so programming only clears bits.
- R9: While protection is active, every read, including the configuration word, returns 0x00 in bits 11:4. Bits 3:0 hold the XOR of the word's three nibbles, so 0xC04 reads as 0x008.
- R10: While protection is active, writes to user addresses 0x040–0x1FF are ignored. Writes to 0x000–0x03F, the ID words and the configuration word still take effect.
- R11: Leaving the mode does not change stored contents.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that samples all pins |
| rst_n | input | 1 | Active-low power-on reset; erases the store |
| hv_level | input | 1 | High-voltage level pin; low holds the block out of mode |
| prog_n | input | 1 | Chip-enable; a falling edge programs, high allows verify |
| step_clk | input | 1 | Increment clock; a falling edge advances the counter |
| data_in | input | 12 | Bus value presented for programming |
| data_out | output | 12 | Bus value driven during verify, 0 otherwise |
| data_oe | output | 1 | Bus drive enable |

## Verification
Several behaviours are checked by the assertions on every cycle. The counter and the configuration selection are held while the level pin is low. The counter wraps from all ones to zero, and the configuration word is never reselected while the mode persists. The bus stays idle outside mode, protected reads keep the upper byte zero, and an unprotected configuration read shows ones in its upper byte. Other behaviours can only be shown by the bench's scenarios. These include the AND write result, the nibble-parity values, the blocked and allowed writes under protection, the ID and unimplemented addresses, the full 2048-step walk, and contents surviving a mode exit.

// File: rtl/eprom_pgm_port.sv
module eprom_pgm_port #(
  parameter int NIB_W      = 4,
  parameter int PC_W       = 11,
  parameter int USER_WORDS = 512,
  parameter int ID_WORDS   = 4,
  parameter int PROT_BASE  = 64,
  parameter int CFG_W      = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 hv_level,
  input  logic                 prog_n,
  input  logic                 step_clk,
  input  logic [3*NIB_W-1:0]   data_in,
  output logic [3*NIB_W-1:0]   data_out,
  output logic                 data_oe
);
  localparam int WORD_W  = 3 * NIB_W;
  localparam int USER_AW = $clog2(USER_WORDS);
  localparam int ID_AW   = (ID_WORDS > 1) ? $clog2(ID_WORDS) : 1;
  localparam logic [PC_W-1:0] USER_TOP = PC_W'(USER_WORDS);
  localparam logic [PC_W-1:0] ID_LO    = PC_W'(USER_WORDS);
  localparam logic [PC_W-1:0] ID_HI    = PC_W'(USER_WORDS + ID_WORDS);
  localparam logic [PC_W-1:0] PROT_LO  = PC_W'(PROT_BASE);

  logic              hv_q, prog_q, step_q;
  logic              active, cfg_sel;
  logic [PC_W-1:0]   pc;
  logic [WORD_W-1:0] user_mem [USER_WORDS];
  logic [WORD_W-1:0] id_mem   [ID_WORDS];
  logic [CFG_W-1:0]  cfg_bits;

  wire entry     = !hv_q && hv_level && prog_n && !step_clk;
  wire step_fall = active && step_q && !step_clk;
  wire prog_fall = active && prog_q && !prog_n;
  wire prot      = !cfg_bits[CFG_W-1];
  wire in_user   = !cfg_sel && (pc < USER_TOP);
  wire in_id     = !cfg_sel && (pc >= ID_LO) && (pc < ID_HI);
  wire blocked   = prot && in_user && (pc >= PROT_LO);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hv_q    <= 1'b0;
      prog_q  <= 1'b1;
      step_q  <= 1'b0;
      active  <= 1'b0;
      cfg_sel <= 1'b1;
      pc      <= '1;
    end else begin
      hv_q   <= hv_level;
      prog_q <= prog_n;
      step_q <= step_clk;
      if (!hv_level) begin
        active  <= 1'b0;
        cfg_sel <= 1'b1;
        pc      <= '1;
      end else if (entry) begin
        active  <= 1'b1;
        cfg_sel <= 1'b1;
        pc      <= '1;
      end else if (step_fall) begin
        pc      <= pc + 1'b1;
        cfg_sel <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < USER_WORDS; i++) user_mem[i] <= '1;
      for (int j = 0; j < ID_WORDS; j++) id_mem[j] <= '1;
      cfg_bits <= '1;
    end else if (prog_fall) begin
      if (cfg_sel)
        cfg_bits <= cfg_bits & data_in[CFG_W-1:0];
      else if (in_user && !blocked)
        user_mem[pc[USER_AW-1:0]] <= user_mem[pc[USER_AW-1:0]] & data_in;
      else if (in_id)
        id_mem[pc[ID_AW-1:0]] <= id_mem[pc[ID_AW-1:0]] & data_in;
    end
  end

  logic [WORD_W-1:0] raw_word, scr_word;

  always_comb begin
    if (cfg_sel)      raw_word = {{(WORD_W-CFG_W){1'b1}}, cfg_bits};
    else if (in_user) raw_word = user_mem[pc[USER_AW-1:0]];
    else if (in_id)   raw_word = id_mem[pc[ID_AW-1:0]];
    else              raw_word = '1;
  end

  assign scr_word = {{(WORD_W-NIB_W){1'b0}},
                     raw_word[3*NIB_W-1:2*NIB_W] ^ raw_word[2*NIB_W-1:NIB_W] ^ raw_word[NIB_W-1:0]};
  assign data_oe  = active && prog_n && step_clk;
  assign data_out = data_oe ? (prot ? scr_word : raw_word) : '0;

  assert_pc_held_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !hv_level |=> (pc == '1) && cfg_sel && !active);

  assert_wrap_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (step_fall && hv_level && pc == '1) |=> (pc == '0));

  assert_no_cfg_return_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_sel && hv_q && hv_level) |=> !cfg_sel);

  assert_bus_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !active |-> !data_oe && data_out == '0);

  assert_prot_upper_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (data_oe && prot) |-> data_out[WORD_W-1:NIB_W] == '0);

  assert_cfg_upper_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (data_oe && cfg_sel && !prot) |-> data_out[WORD_W-1:CFG_W] == '1);
endmodule

// File: tb/test_eprom_pgm_port.sv
module test_eprom_pgm_port;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        hv_level = 1'b0;
  logic        prog_n = 1'b1;
  logic        step_clk = 1'b0;
  logic [11:0] data_in = 12'hFFF;
  logic [11:0] data_out;
  logic        data_oe;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 0;
  logic [10:0] mpc = 11'h7FF;
  bit on_cfg = 1;

  always #2 clk = ~clk;

  eprom_pgm_port i_eprom_pgm_port (
    .clk(clk), .rst_n(rst_n), .hv_level(hv_level), .prog_n(prog_n),
    .step_clk(step_clk), .data_in(data_in), .data_out(data_out), .data_oe(data_oe));

  // {address, programmed value, expected read}, ascending addresses
  localparam logic [34:0] VEC [0:5] = '{
    {11'h000, 12'hC04, 12'hC04},
    {11'h001, 12'hABC, 12'hABC},
    {11'h03F, 12'h123, 12'h123},
    {11'h040, 12'h456, 12'h456},
    {11'h1FF, 12'hF0F, 12'hF0F},
    {11'h200, 12'hFF3, 12'hFF3}
  };

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(string tag, logic [11:0] act, logic [11:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic advance();
    mpc = mpc + 11'd1;
    on_cfg = 0;
  endtask

  task automatic enter();
    hv_level = 0; prog_n = 1; step_clk = 0; tick(3);
    hv_level = 1; tick(3);
    mpc = 11'h7FF; on_cfg = 1;
  endtask

  task automatic leave();
    hv_level = 0; step_clk = 0; prog_n = 1; tick(3);
  endtask

  task automatic pulse();
    step_clk = 1; tick(2); step_clk = 0; tick(2); advance();
  endtask

  task automatic rd(string tag, logic [11:0] exp);
    step_clk = 1; tick(2);
    check(tag, data_oe ? data_out : 12'hxxx, exp);
    step_clk = 0; tick(2); advance();
  endtask

  task automatic wr(logic [11:0] d);
    data_in = d; prog_n = 0; tick(2); prog_n = 1; tick(2); data_in = 12'hFFF;
  endtask

  task automatic goto_addr(logic [10:0] a);
    while (on_cfg || mpc != a) pulse();
  endtask

  initial begin
    tick(3);
    check("R1 reset bus idle", {11'd0, data_oe}, 12'd0);
    rst_n = 1; tick(2);
    check("R1 bus idle after reset", {11'd0, data_oe}, 12'd0);

    // R2: rise with prog_n low, then with step_clk high: no entry
    prog_n = 0; tick(2); hv_level = 1; tick(2); prog_n = 1; step_clk = 1; tick(2);
    check("R2 no entry prog_n low", {11'd0, data_oe}, 12'd0);
    leave();
    prog_n = 1; step_clk = 1; tick(2); hv_level = 1; tick(3);
    check("R2 no entry step_clk high", {11'd0, data_oe}, 12'd0);
    leave();

    enter();
    rd("R3 erased config word", 12'hFFF);
    foreach (VEC[k]) begin
      goto_addr(VEC[k][34:24]);
      wr(VEC[k][23:12]);
      rd($sformatf("R4/R8 table addr %h", VEC[k][34:24]), VEC[k][11:0]);
    end
    goto_addr(11'h204);
    wr(12'h000);
    rd("R5 unimplemented address", 12'hFFF);

    leave(); enter();
    wr(12'hFFE);
    rd("R3 config nibble 1110", 12'hFFE);
    rd("R11 contents kept over exit", 12'hC04);
    goto_addr(11'h7FF);
    rd("R6 2048 steps miss config", 12'hFFF);

    leave(); enter();
    step_clk = 0; prog_n = 1; tick(2);
    check("R7 idle with step_clk low", {11'd0, data_oe}, 12'd0);
    rd("R6 re-entry selects config", 12'hFFE);
    data_in = 12'hFFF; prog_n = 0; step_clk = 1; tick(2);
    check("R7 idle with prog_n low", {11'd0, data_oe}, 12'd0);
    step_clk = 0; tick(2); advance(); prog_n = 1; tick(2);
    goto_addr(11'h001);
    wr(12'h0F0);
    rd("R8 AND write", 12'h0B0);

    leave(); enter();
    wr(12'hFF7);
    rd("R9 protected config", 12'h006);
    rd("R9 protected 0xC04", 12'h008);
    goto_addr(11'h03F);
    wr(12'h0FF);
    rd("R10 low write allowed", 12'h001);
    wr(12'h000);
    rd("R10 write at 0x040 blocked", 12'h007);
    goto_addr(11'h1FF);
    rd("R9 protected 0xF0F", 12'h000);
    wr(12'h0F3);
    rd("R10 ID write allowed", 12'h00C);

    leave(); enter();
    wr(12'hFFD);
    rd("R10 config write allowed", 12'h004);
    leave();

    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    #(4 * 150000);
    if (!done) begin
      done = 1;
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule